// File: doc/BRIEF.md
# Programmable Up-Counter Timer with One Compare Channel

A processor programs this timer through a small synchronous register bus: an address, a write strobe, write data, and read data that follows the address in the same cycle. The counter advances on a counter-clock enable input (`cnt_tick`). A power-of-two prescaler divides that rate. When the count reaches the value in the modulo register, the next advance wraps it to zero and raises a sticky overflow flag. A single compare channel raises its own sticky flag on the advance where the count becomes equal to a programmed compare value. It drives the interrupt output while its enable is set. Both flags are cleared by writing one to them.

The counter width is a build parameter of 16 or 32 bits, and a read-only register reports it. Two small state machines define the behaviour. The run machine has the states STOPPED and RUNNING. A control write whose clock-mode field is 1 takes the transition START. A control write with any other value in that field takes HALT. The channel machine has the states DISABLED and COMPARE. A channel-control write whose mode field is 4 takes ARM. A channel-control write with any other mode value takes DISARM. The register offsets are 0x04 (width), 0x10 (control), 0x14 (count), 0x18 (modulo), 0x1C (status), 0x20 (channel control) and 0x24 (compare).

Top module: `cmp_timer`

## Requirements
- R1: Reads of 0x04 return the counter width in bits 23:16 (0x20 for 32 bits, 0x10 for 16 bits) and zero elsewhere. Writes to 0x04 change nothing.
- R2: In the control register at 0x10, bits 4:3 set the clock mode. Writing 1 enters RUNNING, and the counter then advances once per prescaled tick. Any other value enters STOPPED and freezes the count. The field reads back as 1 in RUNNING and 0 in STOPPED, and bits 2:0 read back as written.
- R3: With prescale code p in control bits 2:0, the count advances once every 2^p ticks of `cnt_tick` (p=3 gives 8 and p=7 gives 128). The prescaler phase restarts at zero while STOPPED and on any count write.
- R4: Offset 0x14 reads the live count, and any write to it forces the count to zero whatever data is written.
- R5: Offset 0x18 holds the modulo value (reset value all ones). An advance from a count equal to the modulo value gives zero.
- R6: Control bit 7 is the overflow flag. It is set by a wrap and cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R7: In the channel control register at 0x20, bits 5:2 hold the mode. The value 4 selects COMPARE and reads back as 4. Every other value selects DISABLED and reads back as 0. Bit 6 is the interrupt enable.
- R8: Channel control bit 7 is set on an advance whose new count equals the compare value at 0x24 while the channel is in COMPARE. It is not set in DISABLED, and it is not set when the count equals the compare value without an advance.
- R9: The channel flag is cleared by writing 1 to channel control bit 7 or to bit 0 of status register 0x1C. Status bit 0 always reads the flag. Writing 0 has no effect, and a match in the same cycle as a clear leaves the flag set.
- R10: `irq` is high exactly while the channel flag and the interrupt enable are both set, and it stays high until the flag is cleared.
- R11: Unimplemented offsets read as zero and ignore writes.
- R12: After reset the control, count, channel control and compare registers read 0, the modulo register reads all ones, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Counter-clock enable, one tick per high cycle |
| irq | output | 1 | Channel interrupt request, level |

## Verification
The assertions assume that the bus is well behaved. A write is a single-cycle strobe with a stable address. The address stays within the 8-bit map, and `cnt_tick` is a synchronous level that is sampled only at the clock edge. The bench drives every input on the falling edge. It keeps `cnt_tick` low during register setup, so each count is set by the exact number of tick cycles issued. The only case that deliberately overlaps an advance with a bus write is the cycle that tests set-over-clear priority.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    typedef enum logic {RUN_STOP, RUN_GO} run_state_t;
    typedef enum logic {CH_OFF, CH_CMP} ch_state_t;

    localparam logic [7:0] OFS_WIDTH = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h14;
    localparam logic [7:0] OFS_MODV  = 8'h18;
    localparam logic [7:0] OFS_STAT  = 8'h1C;
    localparam logic [7:0] OFS_CHCTL = 8'h20;
    localparam logic [7:0] OFS_CHVAL = 8'h24;

    localparam logic [1:0] CKMODE_TICK  = 2'd1;
    localparam logic [3:0] CHMODE_MATCH = 4'd4;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic           tick,
    input  logic [PSW-1:0] sel,
    output logic           step
);
    localparam int PHW = (1 << PSW) - 1;

    logic [PHW-1:0] phase_q;
    logic [PHW-1:0] mask;

    always_comb begin
        mask = ~({PHW{1'b1}} << sel);
        step = run && tick && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
    import cmp_timer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [1:0]    ckmode,
    input  logic          tof_clr,
    input  logic          cnt_wr,
    input  logic          step,
    input  logic [CW-1:0] mod_val,
    output logic          run,
    output logic          adv,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          tof_q
);
    run_state_t st_q, st_d;
    logic       wrap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RUN_STOP;
        else        st_q <= st_d;
    end

    // transitions: START / HALT on control writes
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            unique case (st_q)
                RUN_STOP: if (ckmode == CKMODE_TICK) st_d = RUN_GO;
                RUN_GO:   if (ckmode != CKMODE_TICK) st_d = RUN_STOP;
            endcase
        end
    end

    // outputs
    always_comb begin
        run     = (st_q == RUN_GO);
        adv     = step && !cnt_wr;
        wrap    = adv && (cnt_q == mod_val);
        cnt_nxt = (cnt_q == mod_val) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tof_q <= 1'b0;
        end else begin
            if (cnt_wr)   cnt_q <= '0;
            else if (adv) cnt_q <= cnt_nxt;
            if (wrap)         tof_q <= 1'b1;
            else if (tof_clr) tof_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_wr,
    input  logic [3:0]    ch_mode,
    input  logic          ch_ie,
    input  logic          flag_clr,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_wdata,
    input  logic          adv,
    input  logic [CW-1:0] cnt_nxt,
    output logic          armed,
    output logic          ie_q,
    output logic          flag_q,
    output logic [CW-1:0] cmp_q,
    output logic          irq
);
    ch_state_t st_q, st_d;
    logic      hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // transitions: ARM / DISARM on channel-control writes
    always_comb begin
        st_d = st_q;
        if (ch_wr) begin
            unique case (st_q)
                CH_OFF: if (ch_mode == CHMODE_MATCH) st_d = CH_CMP;
                CH_CMP: if (ch_mode != CHMODE_MATCH) st_d = CH_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        armed = (st_q == CH_CMP);
        hit   = armed && adv && (cnt_nxt == cmp_q);
        irq   = flag_q && ie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (ch_wr)  ie_q  <= ch_ie;
            if (cmp_wr) cmp_q <= cmp_wdata;
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CW  = 32,
    parameter int AW  = 8,
    parameter int PSW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          cnt_tick,
    output logic          irq
);
    localparam logic [7:0] WIDTH_CODE = 8'(CW);

    logic           ctrl_wr, cnt_wr, mod_wr, stat_wr, ch_wr, cmp_wr;
    logic [PSW-1:0] ps_q;
    logic [CW-1:0]  mod_q;
    logic           run, cnt_step, adv, tof_q;
    logic [CW-1:0]  cnt_val, cnt_nxt, cmp_val;
    logic           armed, ie_q, ch_flag;

    always_comb begin
        ctrl_wr = bus_we && (bus_addr == AW'(OFS_CTRL));
        cnt_wr  = bus_we && (bus_addr == AW'(OFS_COUNT));
        mod_wr  = bus_we && (bus_addr == AW'(OFS_MODV));
        stat_wr = bus_we && (bus_addr == AW'(OFS_STAT));
        ch_wr   = bus_we && (bus_addr == AW'(OFS_CHCTL));
        cmp_wr  = bus_we && (bus_addr == AW'(OFS_CHVAL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q  <= '0;
            mod_q <= '1;
        end else begin
            if (ctrl_wr) ps_q  <= bus_wdata[PSW-1:0];
            if (mod_wr)  mod_q <= bus_wdata[CW-1:0];
        end
    end

    cmp_timer_prescale #(.PSW(PSW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_wr),
        .tick    (cnt_tick),
        .sel     (ps_q),
        .step    (cnt_step)
    );

    cmp_timer_count #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .ckmode  (bus_wdata[4:3]),
        .tof_clr (ctrl_wr && bus_wdata[7]),
        .cnt_wr  (cnt_wr),
        .step    (cnt_step),
        .mod_val (mod_q),
        .run     (run),
        .adv     (adv),
        .cnt_q   (cnt_val),
        .cnt_nxt (cnt_nxt),
        .tof_q   (tof_q)
    );

    cmp_timer_chan #(.CW(CW)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_wr     (ch_wr),
        .ch_mode   (bus_wdata[5:2]),
        .ch_ie     (bus_wdata[6]),
        .flag_clr  ((ch_wr && bus_wdata[7]) || (stat_wr && bus_wdata[0])),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (bus_wdata[CW-1:0]),
        .adv       (adv),
        .cnt_nxt   (cnt_nxt),
        .armed     (armed),
        .ie_q      (ie_q),
        .flag_q    (ch_flag),
        .cmp_q     (cmp_val),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_WIDTH): bus_rdata = {8'h00, WIDTH_CODE, 16'h0000};
            AW'(OFS_CTRL):  bus_rdata = {24'h0, tof_q, 3'b000, run, 3'(ps_q)};
            AW'(OFS_COUNT): bus_rdata = 32'(cnt_val);
            AW'(OFS_MODV):  bus_rdata = 32'(mod_q);
            AW'(OFS_STAT):  bus_rdata = {31'h0, ch_flag};
            AW'(OFS_CHCTL): bus_rdata = {24'h0, ch_flag, ie_q,
                                         (armed ? CHMODE_MATCH : 4'd0), 2'b00};
            AW'(OFS_CHVAL): bus_rdata = 32'(cmp_val);
            default:        bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int CW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [31:0]   bus_rdata,
    input logic          irq,
    input logic          run,
    input logic          cnt_step,
    input logic [CW-1:0] cnt_val,
    input logic [CW-1:0] mod_val,
    input logic          tof,
    input logic          ch_flag
);
    logic cnt_wr;
    assign cnt_wr = bus_we && (bus_addr == AW'(8'h14));

    AST_WIDTH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(8'h04)) |-> (bus_rdata == (32'(CW) << 16))); // R1

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_val)); // R2

    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_val == '0)); // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && !cnt_wr && (cnt_val == mod_val)) |=> (tof && (cnt_val == '0))); // R6

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_flag) |-> $past(cnt_step)); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq); // R10
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .run       (run),
    .cnt_step  (cnt_step),
    .cnt_val   (cnt_val),
    .mod_val   (mod_q),
    .tof       (tof_q),
    .ch_flag   (ch_flag)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnt_tick = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 32'hFFFF_FFFF, 32'h0020_0000, 4'd1},  // R1 write ignored
        '{8'h18, 32'h0000_0055, 32'h0000_0055, 4'd5},  // R5 modulo readback
        '{8'h24, 32'h0000_1234, 32'h0000_1234, 4'd8},  // R8 compare readback
        '{8'h10, 32'h0000_000B, 32'h0000_000B, 4'd2},  // R2 mode 1, ps 3
        '{8'h10, 32'h0000_0013, 32'h0000_0003, 4'd2},  // R2 mode 2 stops
        '{8'h20, 32'h0000_0050, 32'h0000_0050, 4'd7},  // R7 compare + ie
        '{8'h20, 32'h0000_0048, 32'h0000_0040, 4'd7},  // R7 mode 2 disabled
        '{8'h20, 32'h0000_0000, 32'h0000_0000, 4'd7},  // R7 off
        '{8'h30, 32'hDEAD_BEEF, 32'h0000_0000, 4'd11}, // R11 hole
        '{8'h14, 32'h0000_ABCD, 32'h0000_0000, 4'd4}   // R4 write zeroes
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic tick(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rchk("R12 ctrl", 8'h10, 32'h0);
        rchk("R12 count", 8'h14, 32'h0);
        rchk("R12 modulo", 8'h18, 32'hFFFF_FFFF);
        rchk("R12 chctl", 8'h20, 32'h0);
        rchk("R12 compare", 8'h24, 32'h0);
        chk("R12 irq", 32'(irq), 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].wd);
            rchk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
        end

        // R2 run then stop
        wr(8'h10, 32'h08);
        tick(6);
        rchk("R2 running count", 8'h14, 32'd6);
        wr(8'h10, 32'h00);
        tick(4);
        rchk("R2 stopped count", 8'h14, 32'd6);

        // R3 prescaler by 8 and by 128
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0B);
        tick(20);
        rchk("R3 div8", 8'h14, 32'd2);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0F);
        tick(256);
        rchk("R3 div128", 8'h14, 32'd2);

        // R5 / R6 wrap and overflow flag
        wr(8'h10, 32'h00);
        wr(8'h18, 32'd4);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        tick(4);
        rchk("R5 at modulo", 8'h14, 32'd4);
        rchk("R6 no flag yet", 8'h10, 32'h08);
        tick(1);
        rchk("R5 wrapped", 8'h14, 32'd0);
        rchk("R6 flag set", 8'h10, 32'h88);
        wr(8'h10, 32'h08);
        rchk("R6 write 0 keeps", 8'h10, 32'h88);
        wr(8'h10, 32'h88);
        rchk("R6 write 1 clears", 8'h10, 32'h08);

        // R8 / R9 / R10 compare with interrupt
        wr(8'h10, 32'h00);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd5);
        wr(8'h20, 32'h50);
        wr(8'h10, 32'h08);
        tick(4);
        rchk("R8 before match", 8'h20, 32'h50);
        chk("R10 irq low", 32'(irq), 32'h0);
        tick(1);
        rchk("R8 match flag", 8'h20, 32'hD0);
        chk("R10 irq high", 32'(irq), 32'h1);
        rchk("R9 status mirror", 8'h1C, 32'h1);
        tick(3);
        chk("R10 irq held", 32'(irq), 32'h1);
        wr(8'h1C, 32'h0);
        rchk("R9 status write 0", 8'h20, 32'hD0);
        wr(8'h1C, 32'h1);
        rchk("R9 status clear", 8'h20, 32'h50);
        chk("R10 irq dropped", 32'(irq), 32'h0);
        rchk("R9 status zero", 8'h1C, 32'h0);
        wr(8'h24, 32'd8);
        rchk("R8 equal without advance", 8'h20, 32'h50);

        // R10 enable off
        wr(8'h14, 32'h0);
        wr(8'h20, 32'h10);
        wr(8'h24, 32'd3);
        tick(3);
        rchk("R8 flag no ie", 8'h20, 32'h90);
        chk("R10 irq masked", 32'(irq), 32'h0);
        wr(8'h20, 32'h90);
        rchk("R9 chctl clear", 8'h20, 32'h10);

        // R7 disabled channel never flags
        wr(8'h20, 32'h00);
        wr(8'h14, 32'h0);
        tick(3);
        rchk("R7 disabled no flag", 8'h20, 32'h00);

        // R9 set wins over clear
        wr(8'h10, 32'h00);
        wr(8'h18, 32'd3);
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd2);
        wr(8'h20, 32'h50);
        wr(8'h10, 32'h08);
        tick(2);
        tick(3);
        bus_addr = 8'h1C; bus_wdata = 32'h1; bus_we = 1'b1; cnt_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; cnt_tick = 1'b0;
        rchk("R9 set wins", 8'h20, 32'hD0);
        rchk("R4 live count", 8'h14, 32'd2);

        summary();
        $finish;
    end
endmodule